// File: doc/BRIEF.md
# Windowed Integer Register File

This block is an integer register file with one write port and two read ports. Each port is addressed by a 5-bit architectural register number. The 32 visible registers are formed from two sources. The first is a small global bank that every procedure sees. The second is a sliding window over a circular stack of windowed storage.

A current-window pointer selects which slice of the stack the windowed numbers refer to. Call and return commands move the pointer one step at a time. Adjacent windows overlap by eight registers. As a result, values a caller places in its outgoing registers show up in the callee's incoming registers, and the reverse holds on return, with no copying.

A window-invalid mask blocks moves onto windows that are still live. A blocked call raises a one-cycle overflow pulse, and a blocked return raises a one-cycle underflow pulse. The pointer stays where it is in both cases. Spilling and trap handling belong to the surrounding logic.

Top module: `wrf_top`

## Requirements
- R1: Register number 0 always reads as zero on both read ports; a write to it is discarded.
- R2: Numbers 1–7 select a global bank that holds the same contents in every window.
- R3: Numbers 16–23 select eight locals private to the current window. A value written there is not visible as a local in any other window, and it is still there when the window is re-entered.
- R4: Numbers 8–15 are the current window's outgoing registers. After a call, the caller's outgoing register k (8+k) reads as incoming register 24+k. A value written to an incoming register before a return reads as the matching outgoing register after the return.
- R5: A call sets the pointer to (pointer−1) mod NWIN, so 0 goes to NWIN−1. A return sets it to (pointer+1) mod NWIN, so NWIN−1 goes to 0. The move takes effect at the clock edge that samples the command.
- R6: When call and return are asserted in the same cycle, both are ignored: the pointer is unchanged and neither flag pulses.
- R7: A call whose target window is marked invalid leaves the pointer unchanged. It drives `ovf_pulse` high for exactly the one cycle after the sampling edge. A return into an invalid window does the same on `unf_pulse`.
- R8: Reads are combinational from the current pointer. A read of the register being written in the same cycle returns the old value, and the new value is readable after the edge.
- R9: After reset the pointer is 0 and both flags are low. The invalid mask has only bit `INV_RST_IDX` set (default 1), and the mask does not change afterwards.
- R10: The two read ports are independent and may address different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_addr | input | 5 | Architectural number, read port A |
| rd_a_data | output | DATA_W | Read data, port A |
| rd_b_addr | input | 5 | Architectural number, read port B |
| rd_b_data | output | DATA_W | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural number, write port |
| wr_data | input | DATA_W | Write data |
| call_req | input | 1 | Move window in the call direction |
| ret_req | input | 1 | Move window in the return direction |
| win_ptr | output | $clog2(NWIN) | Current-window pointer |
| ovf_pulse | output | 1 | One-cycle pulse: call blocked by an invalid window |
| unf_pulse | output | 1 | One-cycle pulse: return blocked by an invalid window |

## Verification
The bench targets the window overlap in both directions. If the incoming registers were mapped to the wrong neighbour, a value passed by the caller would not reach the callee, and a returned value would land in the wrong outgoing register. It walks the pointer from 0 down to the blocked window, then back up through the NWIN−1→0 wrap. This catches modulo errors, and it catches any design that moves the pointer anyway on an overflow, or that keeps the flag high for longer than one cycle. It also checks the case where call and return arrive together, and a same-cycle read of the register being written, where a bypassing design would return the new value too early.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

   typedef enum logic [1:0] {
      GRP_GLOBAL = 2'b00,
      GRP_OUT    = 2'b01,
      GRP_LOCAL  = 2'b10,
      GRP_IN     = 2'b11
   } reg_grp_e;

   function automatic reg_grp_e grp_of(input logic [4:0] arch);
      return reg_grp_e'(arch[4:3]);
   endfunction

endpackage

// File: rtl/wrf_map.sv
module wrf_map #(
   parameter int NWIN = 8,
   localparam int CW  = $clog2(NWIN),
   localparam int PW  = CW + 4
) (
   input  logic [4:0]    arch,
   input  logic [CW-1:0] cwp,
   output logic          is_glb,
   output logic [2:0]    gidx,
   output logic [PW-1:0] pidx
);
   import wrf_pkg::*;

   reg_grp_e      grp;
   logic [CW-1:0] win_sel;
   logic [3:0]    off;

   always_comb begin
      grp    = grp_of(arch);
      is_glb = (grp == GRP_GLOBAL);
      gidx   = arch[2:0];
      if (grp == GRP_IN)
         win_sel = (cwp == CW'(NWIN - 1)) ? '0 : cwp + CW'(1);
      else
         win_sel = cwp;
      off  = (grp == GRP_LOCAL) ? {1'b0, arch[2:0]} : {1'b1, arch[2:0]};
      pidx = {win_sel, off};
   end
endmodule

// File: rtl/wrf_winctl.sv
module wrf_winctl #(
   parameter int NWIN        = 8,
   parameter int INV_RST_IDX = 1,
   localparam int CW         = $clog2(NWIN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          call_req,
   input  logic          ret_req,
   output logic [CW-1:0] cwp,
   output logic          ovf_pulse,
   output logic          unf_pulse
);
   localparam logic [NWIN-1:0] MASK_RST = NWIN'(1) << INV_RST_IDX;

   logic [NWIN-1:0] inv_q;
   logic [CW-1:0]   call_tgt, ret_tgt;
   logic            do_call, do_ret;

   always_comb begin
      call_tgt = (cwp == '0) ? CW'(NWIN - 1) : cwp - CW'(1);
      ret_tgt  = (cwp == CW'(NWIN - 1)) ? '0 : cwp + CW'(1);
      do_call  = call_req && !ret_req;
      do_ret   = ret_req && !call_req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cwp       <= '0;
         inv_q     <= MASK_RST;
         ovf_pulse <= 1'b0;
         unf_pulse <= 1'b0;
      end else begin
         ovf_pulse <= 1'b0;
         unf_pulse <= 1'b0;
         if (do_call) begin
            if (inv_q[call_tgt]) ovf_pulse <= 1'b1;
            else                 cwp       <= call_tgt;
         end else if (do_ret) begin
            if (inv_q[ret_tgt]) unf_pulse <= 1'b1;
            else                cwp       <= ret_tgt;
         end
      end
   end

   a_r5_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cwp) < NWIN);
   a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!call_req && !ret_req) || (call_req && ret_req) |=> $stable(cwp));
   a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_pulse && unf_pulse));
   a_r7_blocked_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_pulse) || $rose(unf_pulse) |-> $stable(cwp));
   a_r9_mask_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      inv_q == MASK_RST);
endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
   parameter int DATA_W = 32,
   parameter int NWIN   = 8,
   localparam int PW    = $clog2(NWIN) + 4,
   localparam int DEPTH = 16 * NWIN,
   localparam int NRD   = 2
) (
   input  logic                     clk,
   input  logic [NRD-1:0]           rd_glb,
   input  logic [NRD-1:0][2:0]      rd_gidx,
   input  logic [NRD-1:0][PW-1:0]   rd_pidx,
   output logic [NRD-1:0][DATA_W-1:0] rd_data,
   input  logic                     wr_en,
   input  logic                     wr_glb,
   input  logic [2:0]               wr_gidx,
   input  logic [PW-1:0]            wr_pidx,
   input  logic [DATA_W-1:0]        wr_data
);
   logic [DATA_W-1:0] glb  [0:7];
   logic [DATA_W-1:0] wmem [0:DEPTH-1];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         if (wr_glb) begin
            if (wr_gidx != 3'd0) glb[wr_gidx] <= wr_data;
         end else begin
            wmem[wr_pidx] <= wr_data;
         end
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      always_comb begin
         if (rd_glb[p])
            rd_data[p] = (rd_gidx[p] == 3'd0) ? '0 : glb[rd_gidx[p]];
         else
            rd_data[p] = wmem[rd_pidx[p]];
      end
   end
endmodule

// File: rtl/wrf_top.sv
module wrf_top #(
   parameter int DATA_W      = 32,
   parameter int NWIN        = 8,
   parameter int INV_RST_IDX = 1,
   localparam int CW         = $clog2(NWIN),
   localparam int PW         = CW + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        rd_a_addr,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [4:0]        rd_b_addr,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [4:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              call_req,
   input  logic              ret_req,
   output logic [CW-1:0]     win_ptr,
   output logic              ovf_pulse,
   output logic              unf_pulse
);
   if (NWIN < 3 || NWIN > 32) begin : g_bad_nwin
      $error("wrf_top: NWIN must lie in 3..32");
   end
   if (INV_RST_IDX < 0 || INV_RST_IDX >= NWIN) begin : g_bad_inv
      $error("wrf_top: INV_RST_IDX out of range");
   end
   if (DATA_W < 1) begin : g_bad_w
      $error("wrf_top: DATA_W must be positive");
   end

   logic [2:0][4:0]    p_arch;
   logic [2:0]         p_glb;
   logic [2:0][2:0]    p_gidx;
   logic [2:0][PW-1:0] p_pidx;
   logic [1:0][DATA_W-1:0] rd_data;

   assign p_arch = {wr_addr, rd_b_addr, rd_a_addr};

   wrf_winctl #(.NWIN(NWIN), .INV_RST_IDX(INV_RST_IDX)) u_ctl (
      .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
      .cwp(win_ptr), .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse)
   );

   for (genvar p = 0; p < 3; p++) begin : g_map
      wrf_map #(.NWIN(NWIN)) u_map (
         .arch(p_arch[p]), .cwp(win_ptr),
         .is_glb(p_glb[p]), .gidx(p_gidx[p]), .pidx(p_pidx[p])
      );
   end

   wrf_store #(.DATA_W(DATA_W), .NWIN(NWIN)) u_store (
      .clk(clk),
      .rd_glb(p_glb[1:0]), .rd_gidx(p_gidx[1:0]), .rd_pidx(p_pidx[1:0]),
      .rd_data(rd_data),
      .wr_en(wr_en), .wr_glb(p_glb[2]), .wr_gidx(p_gidx[2]),
      .wr_pidx(p_pidx[2]), .wr_data(wr_data)
   );

   assign rd_a_data = rd_data[0];
   assign rd_b_data = rd_data[1];

   a_r1_g0_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_addr == 5'd0) |-> (rd_a_data == '0));
endmodule

// File: tb/wrf_top_tb.sv
module wrf_top_tb;
   localparam int W = 32;
   localparam int NWIN = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [4:0]   rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
   logic [W-1:0] rd_a_data, rd_b_data, wr_data = '0;
   logic         wr_en = 1'b0, call_req = 1'b0, ret_req = 1'b0;
   logic [2:0]   win_ptr;
   logic         ovf_pulse, unf_pulse;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   wrf_top #(.DATA_W(W), .NWIN(NWIN), .INV_RST_IDX(1)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
      .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .call_req(call_req), .ret_req(ret_req),
      .win_ptr(win_ptr), .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic [4:0] a, input logic [W-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd_a(input logic [4:0] a, output logic [W-1:0] d);
      rd_a_addr = a; #1; d = rd_a_data;
   endtask

   task automatic cmd(input bit c, input bit r);
      call_req = c; ret_req = r;
      step();
      call_req = 1'b0; ret_req = 1'b0;
   endtask

   task automatic t_reset();
      check("R9 ptr", W'(win_ptr), 0);
      check("R9 ovf", W'(ovf_pulse), 0);
      check("R9 unf", W'(unf_pulse), 0);
   endtask

   task automatic t_zero_reg();
      logic [W-1:0] d;
      wr(5'd0, 32'hDEAD_BEEF);
      rd_a(5'd0, d); check("R1 g0 port A", d, 0);
      rd_b_addr = 5'd0; #1; check("R1 g0 port B", rd_b_data, 0);
   endtask

   task automatic t_same_cycle();
      logic [W-1:0] d;
      wr(5'd9, 32'h0000_0011);
      wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'h0000_0022;
      rd_a(5'd9, d); check("R8 old value same cycle", d, 32'h11);
      step(); wr_en = 1'b0;
      rd_a(5'd9, d); check("R8 new value after edge", d, 32'h22);
   endtask

   task automatic t_overlap();
      logic [W-1:0] d;
      wr(5'd3, 32'hA000_0003);
      wr(5'd16, 32'hB000_0000);
      wr(5'd8, 32'hC000_0008);
      wr(5'd15, 32'hC000_000F);
      rd_a_addr = 5'd3; rd_b_addr = 5'd8; #1;
      check("R10 port A", rd_a_data, 32'hA000_0003);
      check("R10 port B", rd_b_data, 32'hC000_0008);
      cmd(1'b1, 1'b0);
      check("R5 call wraps 0 to NWIN-1", W'(win_ptr), NWIN - 1);
      rd_a(5'd24, d); check("R4 out0 becomes in0", d, 32'hC000_0008);
      rd_a(5'd31, d); check("R4 out7 becomes in7", d, 32'hC000_000F);
      rd_a(5'd3, d);  check("R2 global seen in callee", d, 32'hA000_0003);
      wr(5'd16, 32'hB700_0000);
      rd_a(5'd16, d); check("R3 callee local", d, 32'hB700_0000);
      wr(5'd25, 32'hE000_0025);
      cmd(1'b0, 1'b1);
      check("R5 return wraps NWIN-1 to 0", W'(win_ptr), 0);
      rd_a(5'd16, d); check("R3 caller local kept", d, 32'hB000_0000);
      rd_a(5'd9, d);  check("R4 return value in out1", d, 32'hE000_0025);
   endtask

   task automatic t_walk();
      for (int k = 1; k <= NWIN - 2; k++) begin
         cmd(1'b1, 1'b0);
         check("R5 call step", W'(win_ptr), W'(NWIN - k));
      end
      call_req = 1'b1; step(); call_req = 1'b0;
      check("R7 overflow pulse", W'(ovf_pulse), 1);
      check("R7 ptr held on overflow", W'(win_ptr), 2);
      step();
      check("R7 overflow one cycle", W'(ovf_pulse), 0);
      for (int k = 3; k <= NWIN; k++) begin
         cmd(1'b0, 1'b1);
         check("R5 return step", W'(win_ptr), W'(k % NWIN));
      end
      ret_req = 1'b1; step(); ret_req = 1'b0;
      check("R7 underflow pulse", W'(unf_pulse), 1);
      check("R9 mask bit blocks return, ptr held", W'(win_ptr), 0);
      step();
      check("R7 underflow one cycle", W'(unf_pulse), 0);
   endtask

   task automatic t_both();
      cmd(1'b1, 1'b1);
      check("R6 ptr unchanged", W'(win_ptr), 0);
      check("R6 no ovf", W'(ovf_pulse), 0);
      check("R6 no unf", W'(unf_pulse), 0);
   endtask

   initial begin
      #25 rst_n = 1'b1;
      step();
      t_reset();
      t_zero_reg();
      t_same_cycle();
      t_overlap();
      t_walk();
      t_both();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule